// File: doc/BRIEF.md
# Serial Register-Access Slave with Interrupt-Driven Message Queue

This block is the slave end of a four-wire synchronous serial control port: an active-low select, a serial clock, a data input and a data output, plus an active-low interrupt request. A host microcontroller writes an internal register file through it and reads information back. Each access lasts sixteen serial-clock periods, which is thirty-two transitions. Input and output bits interleave on alternate transitions, so one access carries a 16-bit word in each direction. The incoming word is a command byte followed by a data byte. The command byte holds a 7-bit register address in its upper seven bits and a read-back flag in its lowest bit.

The block does not answer a read-back inside the access that asks for it. It places the answer in an outgoing message queue, together with spontaneous status messages that the surrounding logic posts. While the queue holds anything, the block pulls the interrupt line low. The host then runs another access and receives the oldest message on the data output. The same access can also carry a new command.

All port pins are sampled by a fast system clock. The block counts serial-clock transitions rather than edges of one direction, so it works whether the clock idles low or high.

Top module: `mw_ctrl_port`

## Requirements
- R1: An access is completed only when select rises after exactly 32 serial-clock transitions seen while select was low. The 16-bit incoming word is taken MSB first. Bits [15:9] are the address, bit [8] is the read-back flag (1 = read-back request, 0 = write) and bits [7:0] are the data byte.
- R2: In mode A (the reset mode), input bit i is sampled on transition 2i+1. Output bit 0 is driven from the fall of select. Output bit i (i>=1) is driven from transition 2i.
- R3: In mode B, output bit i is driven from transition 2i+1 and input bit i is sampled on transition 2i+2. A completed write to address 0x7F sets the mode from data bit 0 (1 = mode B). The new mode applies from the next access and is visible on `mode_b`.
- R4: The serial clock may idle either low or high before select falls, and the access behaves the same in both cases.
- R5: A completed write to an address below NUM_REGS loads that register, exposed as byte `addr` of `reg_q`. A write to any other address except 0x7F changes nothing.
- R6: A completed read-back request queues the message {address, 1, register content}, where content is {7'b0, mode} for 0x7F and zero for unmapped addresses. Its data byte is ignored and no register changes.
- R7: A one-cycle `evt_valid` pulse queues {evt_addr, 0, evt_data}. Messages leave the queue oldest first, so a read-back answer follows any messages queued before it.
- R8: During an access the oldest pending message is shifted out, or all zeros if none is pending. While select is high, `sdo_oe` is low and `sdo` is 0.
- R9: `int_n` is low while select is high and a message is pending. It is high while select is low, and it cannot fall while select is low. A message is removed only by a completed access.
- R10: The queue holds Q_DEPTH (4) messages. A message offered to a full queue is dropped and sets `ovf`, which stays set until reset.
- R11: An access ending with any transition count other than 32 is discarded. It writes nothing, queues nothing and consumes no message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select from the host |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host (0 when not enabled) |
| sdo_oe | output | 1 | Output enable for sdo; low means high impedance |
| int_n | output | 1 | Active-low message-pending request |
| evt_valid | input | 1 | One-cycle strobe posting a spontaneous message |
| evt_addr | input | 7 | Address field of the posted message |
| evt_data | input | 8 | Data field of the posted message |
| reg_q | output | NUM_REGS*8 | Register file contents, register n at bits [8n+7:8n] |
| mode_b | output | 1 | 1 when the interleave mode is B |
| ovf | output | 1 | Sticky queue overflow flag |

## Verification
Directed accesses cover the two clock idle levels and both interleave modes. Comparing their replies shows whether sampling and driving sit on the correct parity of transition. Sequences that mix posted events with read-back requests check that replies come out in queue order and not by priority. A fill past four entries shows where messages are dropped. Accesses cut short at several transition counts separate discard from partial commit. Seeded random accesses then mix addresses inside and outside the register range, mode toggles, idle levels and event posts, and every reply and register value is compared with a bench model.

// File: rtl/mw_pkg.sv
`timescale 1ns/1ps
package mw_pkg;
  localparam int ADDR_W  = 7;
  localparam int DATA_W  = 8;
  localparam int WORD_W  = ADDR_W + 1 + DATA_W;
  localparam int XFER_TR = 2 * WORD_W;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              rb;
    logic [DATA_W-1:0] data;
  } mw_msg_t;
endpackage

// File: rtl/mw_sync.sv
`timescale 1ns/1ps
module mw_sync #(
  parameter int         W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q, hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      hold_q <= RST_VAL;
    end else begin
      meta_q <= d;
      hold_q <= meta_q;
    end
  end

  assign q = hold_q;
endmodule

// File: rtl/mw_shift_engine.sv
`timescale 1ns/1ps
module mw_shift_engine
  import mw_pkg::*;
#(
  parameter int EDGES = XFER_TR,
  parameter int W     = WORD_W,
  localparam int CNT_W = $clog2(EDGES + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_s,
  input  logic             sclk_s,
  input  logic             sdi_s,
  input  logic             mode_b,
  input  logic             tx_valid,
  input  logic [W-1:0]     tx_word,
  output logic             sdo,
  output logic             sdo_oe,
  output logic             cs_prev,
  output logic             done,
  output logic             loaded,
  output logic [W-1:0]     rx_word,
  output logic [CNT_W-1:0] edge_cnt
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(EDGES);
  localparam logic [CNT_W-1:0] SAT  = CNT_W'(EDGES + 1);

  logic             cs_d_q, sclk_d_q, mode_q, loaded_q, sdo_q, oe_q, done_q;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [W-1:0]     in_q, in_n, out_q, out_n;
  logic             mode_n, loaded_n, sdo_n, done_n;
  logic             cs_fall, cs_rise, tr_seen, in_slot;
  logic [W-1:0]     first_word;

  assign cs_fall    = cs_d_q & ~cs_s;
  assign cs_rise    = ~cs_d_q & cs_s;
  assign tr_seen    = ~cs_s & ~cs_d_q & (sclk_s ^ sclk_d_q);
  assign in_slot    = (cnt_q[0] == mode_q);
  assign first_word = tx_valid ? tx_word : '0;

  always_comb begin
    cnt_n    = cnt_q;
    in_n     = in_q;
    out_n    = out_q;
    sdo_n    = sdo_q;
    mode_n   = mode_q;
    loaded_n = loaded_q;
    done_n   = cs_rise && (cnt_q == LAST);
    if (cs_fall) begin
      cnt_n    = '0;
      in_n     = '0;
      mode_n   = mode_b;
      loaded_n = tx_valid;
      if (mode_b) begin
        out_n = first_word;
        sdo_n = 1'b0;
      end else begin
        out_n = {first_word[W-2:0], 1'b0};
        sdo_n = first_word[W-1];
      end
    end else if (tr_seen && (cnt_q != SAT)) begin
      cnt_n = cnt_q + 1'b1;
      if (cnt_q < LAST) begin
        if (in_slot) begin
          in_n = {in_q[W-2:0], sdi_s};
        end else begin
          sdo_n = out_q[W-1];
          out_n = {out_q[W-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_d_q   <= 1'b1;
      sclk_d_q <= 1'b0;
      cnt_q    <= '0;
      in_q     <= '0;
      out_q    <= '0;
      sdo_q    <= 1'b0;
      oe_q     <= 1'b0;
      mode_q   <= 1'b0;
      loaded_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      cs_d_q   <= cs_s;
      sclk_d_q <= sclk_s;
      cnt_q    <= cnt_n;
      in_q     <= in_n;
      out_q    <= out_n;
      sdo_q    <= sdo_n;
      oe_q     <= ~cs_s;
      mode_q   <= mode_n;
      loaded_q <= loaded_n;
      done_q   <= done_n;
    end
  end

  assign sdo      = sdo_q & oe_q;
  assign sdo_oe   = oe_q;
  assign cs_prev  = cs_d_q;
  assign done     = done_q;
  assign loaded   = loaded_q;
  assign rx_word  = in_q;
  assign edge_cnt = cnt_q;
endmodule

// File: rtl/mw_msgq.sv
`timescale 1ns/1ps
module mw_msgq #(
  parameter int DEPTH = 4,
  parameter int W     = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_a,
  input  logic [W-1:0]     din_a,
  input  logic             push_b,
  input  logic [W-1:0]     din_b,
  input  logic             pop,
  output logic [W-1:0]     head,
  output logic             valid,
  output logic [CNT_W-1:0] count,
  output logic             ovf
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] rd_q, wr_q, rd_n, wr_n, wr_b;
  logic [CNT_W-1:0] cnt_q, cnt_n, base;
  logic             ovf_q, ovf_n, take, acc_a, acc_b;

  always_comb begin
    take  = pop & (cnt_q != '0);
    base  = cnt_q - {{(CNT_W-1){1'b0}}, take};
    acc_a = push_a & (base < FULL);
    acc_b = push_b & ((base + {{(CNT_W-1){1'b0}}, acc_a}) < FULL);
    wr_b  = wr_q + {{(PTR_W-1){1'b0}}, acc_a};
    rd_n  = rd_q + {{(PTR_W-1){1'b0}}, take};
    wr_n  = wr_b + {{(PTR_W-1){1'b0}}, acc_b};
    cnt_n = base + {{(CNT_W-1){1'b0}}, acc_a} + {{(CNT_W-1){1'b0}}, acc_b};
    ovf_n = ovf_q | (push_a & ~acc_a) | (push_b & ~acc_b);
  end

  always_ff @(posedge clk) begin
    if (acc_a) mem_q[wr_q] <= din_a;
    if (acc_b) mem_q[wr_b] <= din_b;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      rd_q  <= rd_n;
      wr_q  <= wr_n;
      cnt_q <= cnt_n;
      ovf_q <= ovf_n;
    end
  end

  assign head  = mem_q[rd_q];
  assign valid = (cnt_q != '0);
  assign count = cnt_q;
  assign ovf   = ovf_q;
endmodule

// File: rtl/mw_ctrl_port.sv
`timescale 1ns/1ps
module mw_ctrl_port
  import mw_pkg::*;
#(
  parameter int                NUM_REGS  = 8,
  parameter int                Q_DEPTH   = 4,
  parameter logic [ADDR_W-1:0] MODE_ADDR = 7'h7F
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cs_n,
  input  logic                       sclk,
  input  logic                       sdi,
  output logic                       sdo,
  output logic                       sdo_oe,
  output logic                       int_n,
  input  logic                       evt_valid,
  input  logic [ADDR_W-1:0]          evt_addr,
  input  logic [DATA_W-1:0]          evt_data,
  output logic [NUM_REGS*DATA_W-1:0] reg_q,
  output logic                       mode_b,
  output logic                       ovf
);
  localparam int QC_W  = $clog2(Q_DEPTH + 1);
  localparam int TRC_W = $clog2(XFER_TR + 2);

  logic [1:0]        rst_pipe_q;
  logic              rst_n_s;
  logic [2:0]        pins_s;
  logic              cs_s, cs_prev, done, loaded, done_wr;
  logic              mode_q, mode_n, int_q, int_n_nx;
  logic [WORD_W-1:0] rx_word, head_word;
  mw_msg_t           rx, rb_msg, ev_msg;
  logic [DATA_W-1:0] rd_data;
  logic              q_valid;
  logic [QC_W-1:0]   q_count;
  logic [TRC_W-1:0]  edge_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_s = rst_pipe_q[1];

  mw_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n_s), .d({cs_n, sclk, sdi}), .q(pins_s)
  );
  assign cs_s = pins_s[2];

  mw_shift_engine #(.EDGES(XFER_TR), .W(WORD_W)) u_engine (
    .clk(clk), .rst_n(rst_n_s), .cs_s(cs_s), .sclk_s(pins_s[1]), .sdi_s(pins_s[0]),
    .mode_b(mode_q), .tx_valid(q_valid), .tx_word(head_word),
    .sdo(sdo), .sdo_oe(sdo_oe), .cs_prev(cs_prev), .done(done), .loaded(loaded),
    .rx_word(rx_word), .edge_cnt(edge_cnt)
  );

  assign rx      = mw_msg_t'(rx_word);
  assign done_wr = done & ~rx.rb;

  genvar g;
  generate
    for (g = 0; g < NUM_REGS; g++) begin : g_reg
      logic [DATA_W-1:0] r_q;
      logic              we;
      assign we = done_wr & (rx.addr == ADDR_W'(g));
      always_ff @(posedge clk or negedge rst_n_s) begin
        if (!rst_n_s)  r_q <= '0;
        else if (we)   r_q <= rx.data;
      end
      assign reg_q[g*DATA_W +: DATA_W] = r_q;
    end
  endgenerate

  always_comb begin
    rd_data = '0;
    if (rx.addr == MODE_ADDR)            rd_data = {{(DATA_W-1){1'b0}}, mode_q};
    else if (int'(rx.addr) < NUM_REGS)   rd_data = reg_q[int'(rx.addr)*DATA_W +: DATA_W];
  end

  always_comb begin
    mode_n = mode_q;
    if (done_wr && (rx.addr == MODE_ADDR)) mode_n = rx.data[0];
  end

  assign rb_msg = '{addr: rx.addr, rb: 1'b1, data: rd_data};
  assign ev_msg = '{addr: evt_addr, rb: 1'b0, data: evt_data};

  mw_msgq #(.DEPTH(Q_DEPTH), .W(WORD_W)) u_queue (
    .clk(clk), .rst_n(rst_n_s),
    .push_a(done & rx.rb), .din_a(rb_msg),
    .push_b(evt_valid),    .din_b(ev_msg),
    .pop(done & loaded),
    .head(head_word), .valid(q_valid), .count(q_count), .ovf(ovf)
  );

  assign int_n_nx = ~(cs_s & cs_prev & ~done & q_valid);

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      mode_q <= 1'b0;
      int_q  <= 1'b1;
    end else begin
      mode_q <= mode_n;
      int_q  <= int_n_nx;
    end
  end

  assign int_n  = int_q;
  assign mode_b = mode_q;
endmodule

// File: rtl/mw_ctrl_port_chk.sv
`timescale 1ns/1ps
module mw_ctrl_port_chk #(
  parameter int NUM_REGS = 8,
  parameter int Q_DEPTH  = 4,
  localparam int QC_W  = $clog2(Q_DEPTH + 1),
  localparam int TRC_W = $clog2(32 + 2)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  int_n,
  input logic                  cs_s,
  input logic                  sdo,
  input logic                  sdo_oe,
  input logic                  ovf,
  input logic [QC_W-1:0]       q_count,
  input logic [NUM_REGS*8-1:0] reg_q,
  input logic                  done_wr,
  input logic [TRC_W-1:0]      edge_cnt
);
  a_r9_int_no_fall_cs_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(int_n) |-> $past(cs_s));

  a_r9_int_released_cs_low: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_s |=> int_n);

  a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= QC_W'(Q_DEPTH));

  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);

  a_r11_write_needs_completion: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(reg_q) |-> $past(done_wr));

  a_r8_sdo_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_oe |-> !sdo);

  a_r1_count_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    edge_cnt <= TRC_W'(33));
endmodule

bind mw_ctrl_port mw_ctrl_port_chk #(.NUM_REGS(NUM_REGS), .Q_DEPTH(Q_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .int_n(int_n), .cs_s(cs_s), .sdo(sdo), .sdo_oe(sdo_oe),
  .ovf(ovf), .q_count(q_count), .reg_q(reg_q), .done_wr(done_wr), .edge_cnt(edge_cnt)
);

// File: tb/mw_ctrl_port_bench.sv
`timescale 1ns/1ps
module mw_ctrl_port_bench;
  localparam int NR = 8;
  localparam int QD = 4;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic evt_valid = 1'b0;
  logic [6:0] evt_addr = '0;
  logic [7:0] evt_data = '0;
  logic sdo, sdo_oe, int_n, mode_b, ovf;
  logic [NR*8-1:0] reg_q;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  logic [7:0]  mreg [NR];
  logic [15:0] mq [QD];
  int  mcnt = 0;
  bit  bmode = 1'b0, movf = 1'b0;

  always #2.5 clk = ~clk;

  mw_ctrl_port #(.NUM_REGS(NR), .Q_DEPTH(QD)) u_mw_ctrl_port (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .sdo(sdo),
    .sdo_oe(sdo_oe), .int_n(int_n), .evt_valid(evt_valid), .evt_addr(evt_addr),
    .evt_data(evt_data), .reg_q(reg_q), .mode_b(mode_b), .ovf(ovf)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mrd(input logic [6:0] a);
    if (a == 7'h7F) return {7'b0, bmode};
    if (int'(a) < NR) return mreg[a];
    return 8'h00;
  endfunction

  function automatic logic [NR*8-1:0] mflat();
    logic [NR*8-1:0] f;
    for (int i = 0; i < NR; i++) f[i*8 +: 8] = mreg[i];
    return f;
  endfunction

  task automatic mpush(input logic [15:0] w);
    if (mcnt < QD) begin mq[mcnt] = w; mcnt++; end
    else movf = 1'b1;
  endtask

  task automatic mpop();
    for (int i = 0; i < QD - 1; i++) mq[i] = mq[i+1];
    mcnt--;
  endtask

  task automatic post_evt(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    evt_valid = 1'b1; evt_addr = a; evt_data = d;
    @(negedge clk);
    evt_valid = 1'b0;
    mpush({a, 1'b0, d});
    repeat (6) @(negedge clk);
    chk("R9 int low with pending message", {63'b0, int_n}, {63'b0, (mcnt == 0)});
  endtask

  task automatic access(input logic [15:0] word, input int nedges, input logic idle,
                        input string tag);
    logic [15:0] got, exp;
    int ib;
    exp = (mcnt > 0) ? mq[0] : 16'h0000;
    got = '0;
    ib  = 0;
    sclk = idle;
    repeat (4) @(negedge clk);
    cs_n = 1'b0;
    repeat (10) @(negedge clk);
    chk({tag, " R9 int high under select"}, {63'b0, int_n}, 64'd1);
    for (int e = 1; e <= nedges; e++) begin
      automatic bit in_e = bmode ? (e % 2 == 0) : (e % 2 == 1);
      if (in_e) begin
        sdi = word[15 - ib];
        repeat (4) @(negedge clk);
        got[15 - ib] = sdo;
        ib++;
        repeat (4) @(negedge clk);
      end else begin
        repeat (8) @(negedge clk);
      end
      sclk = ~sclk;
    end
    repeat (8) @(negedge clk);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
    sclk = idle;
    repeat (12) @(negedge clk);
    if (nedges == 32) begin
      chk({tag, bmode ? " R3" : " R2", " R8 reply word"}, {48'b0, got}, {48'b0, exp});
      if (mcnt > 0) mpop();
      if (word[8]) mpush({word[15:9], 1'b1, mrd(word[15:9])});
      else begin
        if (int'(word[15:9]) < NR) mreg[word[15:9]] = word[7:0];
        if (word[15:9] == 7'h7F) bmode = word[0];
      end
    end
    chk({tag, " R5 R11 register file"}, reg_q, mflat());
    chk({tag, " R9 int after access"}, {63'b0, int_n}, {63'b0, (mcnt == 0)});
    chk({tag, " R8 output disabled"}, {62'b0, sdo_oe, sdo}, 64'd0);
    chk({tag, " R3 mode"}, {63'b0, mode_b}, {63'b0, bmode});
    chk({tag, " R10 overflow"}, {63'b0, ovf}, {63'b0, movf});
  endtask

  task automatic drain(input string tag);
    while (mcnt > 0) access({7'h50, 1'b0, 8'h00}, 32, 1'b0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R1 watchdog actual hung expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NR; i++) mreg[i] = 8'h00;
    void'($urandom(32'h5EED_0042));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    chk("R9 reset int_n", {63'b0, int_n}, 64'd1);
    chk("R8 reset output off", {62'b0, sdo_oe, sdo}, 64'd0);
    chk("R5 reset registers", reg_q, '0);
    chk("R3 reset mode A", {63'b0, mode_b}, 64'd0);
    chk("R10 reset ovf", {63'b0, ovf}, 64'd0);

    // R2 R5 R8: write in mode A, idle low, nothing pending
    access({7'd3, 1'b0, 8'hA5}, 32, 1'b0, "R5 write r3");
    // R6: read-back with junk data byte, then reply delivered
    access({7'd3, 1'b1, 8'hFF}, 32, 1'b0, "R6 readback r3");
    access({7'h50, 1'b0, 8'h77}, 32, 1'b0, "R5 unmapped write R6 reply");
    // R4: idle-high clock
    access({7'd1, 1'b0, 8'h3C}, 32, 1'b1, "R4 idle high write");
    access({7'd1, 1'b1, 8'h00}, 32, 1'b1, "R4 idle high readback");
    access({7'd0, 1'b0, 8'h11}, 32, 1'b0, "R4 reply");
    // R7: event queued before a read-back comes out first
    post_evt(7'h22, 8'h5A);
    access({7'd1, 1'b1, 8'h00}, 32, 1'b0, "R7 evt then readback");
    access({7'd2, 1'b0, 8'h99}, 32, 1'b0, "R7 readback second");
    // R11: aborted accesses
    post_evt(7'h33, 8'hC3);
    access({7'd4, 1'b0, 8'hEE}, 20, 1'b0, "R11 abort 20");
    access({7'd4, 1'b0, 8'hEE}, 31, 1'b1, "R11 abort 31");
    access({7'd4, 1'b1, 8'hEE}, 7, 1'b0, "R11 abort readback");
    access({7'd5, 1'b0, 8'h01}, 32, 1'b0, "R11 message kept");
    // R3: switch to mode B
    access({7'h7F, 1'b0, 8'h01}, 32, 1'b0, "R3 set mode B");
    access({7'd6, 1'b0, 8'h6B}, 32, 1'b1, "R3 write in B");
    access({7'h7F, 1'b1, 8'h00}, 32, 1'b0, "R3 readback mode");
    access({7'd6, 1'b1, 8'h00}, 32, 1'b0, "R3 reply mode");
    drain("R3 drain");
    // R10: overflow drops the fifth message
    for (int i = 0; i < 5; i++) post_evt(7'(8'h40 + i), 8'(8'h80 + i));
    chk("R10 ovf set", {63'b0, ovf}, 64'd1);
    drain("R10 drain order");
    access({7'h7F, 1'b0, 8'h00}, 32, 1'b1, "R3 back to mode A");

    for (int n = 0; n < 40; n++) begin
      automatic logic [6:0] a = ($urandom % 8 == 0) ? 7'h7F : 7'($urandom % 10);
      automatic logic rb = 1'($urandom % 2);
      automatic logic [7:0] d = 8'($urandom);
      automatic int ne = ($urandom % 8 == 0) ? int'(1 + $urandom % 31) : 32;
      if ($urandom % 4 == 0) post_evt(7'($urandom), 8'($urandom));
      access({a, rb, d}, ne, 1'($urandom % 2), "R1 random");
    end
    drain("R7 final drain");

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule